// File: doc/BRIEF.md
# 64-bit Alarm Timer with Snapshot

This block is a free-running 64-bit up-counter with a 32-bit register port. In fast mode the counter advances by one every `divider` clock cycles. In slow mode it instead adds a fixed-point step on each strobe from a slow-clock domain. Software never reads the live count directly. It writes a snapshot trigger, and the count is captured into two readable 32-bit halves. A new 64-bit count is staged in two halves and applied by writing a load trigger.

A 64-bit alarm value is compared against the count using greater-than-or-equal. When the alarm is enabled and the count has reached the alarm value, a sticky status bit is set. The interrupt output, gated by an enable bit, follows that status bit in level mode. In edge mode it gives a one-cycle pulse instead.

Two small state machines carry the control. The snapshot machine has states `SN_IDLE` and `SN_WAIT`. A trigger write moves it from `SN_IDLE` to `SN_WAIT` (transition "request"). It returns to `SN_IDLE` when the capture happens (transition "capture"). The capture happens on the next counter advance or load, or on the next cycle if the counter is stopped. The alarm machine has states `AL_IDLE` and `AL_FIRED`. A comparison hit while enabled moves it from `AL_IDLE` to `AL_FIRED` (transition "fire"). A clear write returns it to `AL_IDLE` (transition "acknowledge"). A clear written in `AL_IDLE` leaves it in `AL_IDLE`.

Top module: `alarm_timer64`

## Requirements
- R1: After reset: control (byte 0x00) reads 0, load halves (0x10, 0x14) read 0, alarm halves (0x08 low, 0x0C high) read 0xFFFFFFFF, snapshot halves (0x20 low, 0x24 high) read 0, status reads 0 and `irq` is 0.
- R2: The count advances by one per tick only while control bit 0 (run) and bit 1 (count up) are both set and bit 4 (slow) is clear. The tick period is max(divider,1) clock cycles, with the divider in control bits [31:16]. With run or count up clear, the count holds.
- R3: Writing any value to 0x1C requests a snapshot. The count is captured into 0x20/0x24 at the next counter advance or load, or one cycle after the request if the counter is stopped. The captured value holds until the next request.
- R4: Writing 0x18 replaces the whole 64-bit count with {0x14, 0x10} at that clock edge, with carries across the 32-bit boundary handled normally afterwards.
- R5: With control bit 4 set (and run and count up set), each `slow_stb` cycle adds the step register (0x04, unsigned, 19 fractional bits) to an 83-bit accumulator whose integer part is the count. Fast ticks are suppressed.
- R6: When control bit 3 (alarm enable) is set and count >= {0x0C, 0x08}, status (0x2C bit 0) becomes 1 on the next clock edge. An alarm at or below the current count fires at once.
- R7: Clearing alarm enable stops new status assertion but keeps a status bit that is already set.
- R8: Writing 1 in bit 0 of 0x30 clears status at that edge.
- R9: With control bit 2 (level) set, `irq` equals status AND interrupt enable (0x28 bit 0).
- R10: With control bit 2 clear, `irq` is high for exactly one cycle, in the first cycle status is 1, if interrupt enable is set.
- R11: Reads of unmapped or misaligned addresses, and of the write-only triggers 0x18, 0x1C and 0x30, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_stb | input | 1 | One-cycle strobe per slow-clock period |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `slow_stb` is a clean one-cycle, clock-synchronous strobe and that writes arrive one per cycle at aligned addresses. The snapshot-return check assumes software does not retrigger a snapshot while one is pending. The bench drives every input on the falling edge and stops the counter before it reprograms the divider, the load value or the alarm. It also turns alarm enable off before writing a clear, so a still-true comparison cannot re-fire straight after the acknowledge.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    // word indices (byte address / 4)
    localparam logic [5:0] W_CTRL     = 6'd0;
    localparam logic [5:0] W_STEP     = 6'd1;
    localparam logic [5:0] W_ALM_LO   = 6'd2;
    localparam logic [5:0] W_ALM_HI   = 6'd3;
    localparam logic [5:0] W_LD_LO    = 6'd4;
    localparam logic [5:0] W_LD_HI    = 6'd5;
    localparam logic [5:0] W_LD_GO    = 6'd6;
    localparam logic [5:0] W_SNAP_GO  = 6'd7;
    localparam logic [5:0] W_SNAP_LO  = 6'd8;
    localparam logic [5:0] W_SNAP_HI  = 6'd9;
    localparam logic [5:0] W_IRQ_EN   = 6'd10;
    localparam logic [5:0] W_IRQ_STAT = 6'd11;
    localparam logic [5:0] W_IRQ_CLR  = 6'd12;

    // control bit positions
    localparam int B_RUN   = 0;
    localparam int B_UP    = 1;
    localparam int B_LEVEL = 2;
    localparam int B_ALEN  = 3;
    localparam int B_SLOW  = 4;
    localparam int DIV_LSB = 16;

    typedef enum logic {SN_IDLE, SN_WAIT} snap_state_t;
    typedef enum logic {AL_IDLE, AL_FIRED} alarm_state_t;
endpackage

// File: rtl/atmr_regs.sv
module atmr_regs
    import atmr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              run_en,
    output logic              count_up,
    output logic              level_mode,
    output logic              alarm_en,
    output logic              slow_sel,
    output logic [DIV_W-1:0]  divider,
    output logic [DATA_W-1:0] step,
    output logic [CNT_W-1:0]  alarm_val,
    output logic [CNT_W-1:0]  load_val,
    output logic              irq_en,
    output logic              ld_go,
    output logic              snap_go,
    output logic              clr_go,
    input  logic [CNT_W-1:0]  snap,
    input  logic              status
);
    localparam int HALF = CNT_W / 2;

    logic       aligned;
    logic [5:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];

    assign ld_go   = we && aligned && (widx == W_LD_GO);
    assign snap_go = we && aligned && (widx == W_SNAP_GO);
    assign clr_go  = we && aligned && (widx == W_IRQ_CLR) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en     <= 1'b0;
            count_up   <= 1'b0;
            level_mode <= 1'b0;
            alarm_en   <= 1'b0;
            slow_sel   <= 1'b0;
            divider    <= '0;
            step       <= '0;
            alarm_val  <= '1;
            load_val   <= '0;
            irq_en     <= 1'b0;
        end else if (we && aligned) begin
            unique case (widx)
                W_CTRL: begin
                    run_en     <= wdata[B_RUN];
                    count_up   <= wdata[B_UP];
                    level_mode <= wdata[B_LEVEL];
                    alarm_en   <= wdata[B_ALEN];
                    slow_sel   <= wdata[B_SLOW];
                    divider    <= wdata[DIV_LSB +: DIV_W];
                end
                W_STEP:   step <= wdata;
                W_ALM_LO: alarm_val[HALF-1:0]     <= wdata;
                W_ALM_HI: alarm_val[CNT_W-1:HALF] <= wdata;
                W_LD_LO:  load_val[HALF-1:0]      <= wdata;
                W_LD_HI:  load_val[CNT_W-1:HALF]  <= wdata;
                W_IRQ_EN: irq_en <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (widx)
                W_CTRL: begin
                    rdata[B_RUN]   = run_en;
                    rdata[B_UP]    = count_up;
                    rdata[B_LEVEL] = level_mode;
                    rdata[B_ALEN]  = alarm_en;
                    rdata[B_SLOW]  = slow_sel;
                    rdata[DIV_LSB +: DIV_W] = divider;
                end
                W_STEP:     rdata = step;
                W_ALM_LO:   rdata = alarm_val[HALF-1:0];
                W_ALM_HI:   rdata = alarm_val[CNT_W-1:HALF];
                W_LD_LO:    rdata = load_val[HALF-1:0];
                W_LD_HI:    rdata = load_val[CNT_W-1:HALF];
                W_SNAP_LO:  rdata = snap[HALF-1:0];
                W_SNAP_HI:  rdata = snap[CNT_W-1:HALF];
                W_IRQ_EN:   rdata[0] = irq_en;
                W_IRQ_STAT: rdata[0] = status;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/atmr_counter.sv
module atmr_counter
    import atmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 19,
    parameter int DIV_W  = 16,
    parameter int STEP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              count_up,
    input  logic              slow_sel,
    input  logic [DIV_W-1:0]  divider,
    input  logic [STEP_W-1:0] step,
    input  logic              slow_stb,
    input  logic              ld_go,
    input  logic [CNT_W-1:0]  ld_val,
    input  logic              snap_go,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  snap
);
    localparam int ACC_W = CNT_W + FRAC_W;
    localparam logic [ACC_W-1:0] ONE_TICK = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [DIV_W-1:0] pre_q, pre_d;
    logic             counting, fast_tick, slow_tick, cap_now;
    snap_state_t      sn_q, sn_d;
    logic [CNT_W-1:0] snap_q;

    assign counting = run_en && count_up;

    // prescaler
    always_comb begin
        pre_d     = pre_q;
        fast_tick = 1'b0;
        if (!counting || slow_sel) begin
            pre_d = '0;
        end else if (divider <= DIV_W'(1) || pre_q >= divider - DIV_W'(1)) begin
            fast_tick = 1'b1;
            pre_d     = '0;
        end else begin
            pre_d = pre_q + DIV_W'(1);
        end
    end

    assign slow_tick = counting && slow_sel && slow_stb;

    // accumulator: integer count above FRAC_W fractional bits
    always_comb begin
        if (ld_go)          acc_d = {ld_val, FRAC_W'(0)};
        else if (fast_tick) acc_d = acc_q + ONE_TICK;
        else if (slow_tick) acc_d = acc_q + ACC_W'(step);
        else                acc_d = acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            pre_q <= '0;
        end else begin
            acc_q <= acc_d;
            pre_q <= pre_d;
        end
    end

    assign count = acc_q[ACC_W-1:FRAC_W];

    // snapshot state machine
    assign cap_now = (sn_q == SN_WAIT) &&
                     (fast_tick || slow_tick || ld_go || !counting);

    always_comb begin
        sn_d = sn_q;
        unique case (sn_q)
            SN_IDLE: if (snap_go) sn_d = SN_WAIT;
            SN_WAIT: if (cap_now && !snap_go) sn_d = SN_IDLE;
            default: sn_d = SN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sn_q <= SN_IDLE;
        else        sn_q <= sn_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (cap_now) snap_q <= acc_d[ACC_W-1:FRAC_W];
    end

    assign snap = snap_q;

    a_r4_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> (count == $past(ld_val)));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !ld_go) |=> $stable(count));

    a_r3_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_q == SN_IDLE && !snap_go) |=> $stable(snap));

    a_r3_stopped_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_q == SN_WAIT && !counting && !snap_go) |=> (sn_q == SN_IDLE));
endmodule

// File: rtl/atmr_alarm.sv
module atmr_alarm
    import atmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             alarm_en,
    input  logic             level_mode,
    input  logic             irq_en,
    input  logic             clr_go,
    output logic             status,
    output logic             irq
);
    alarm_state_t st_q, st_d;
    logic         hit, pulse_q;

    assign hit = alarm_en && (count >= alarm_val);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AL_IDLE:  if (!clr_go && hit) st_d = AL_FIRED;
            AL_FIRED: if (clr_go)         st_d = AL_IDLE;
            default:  st_d = AL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= AL_IDLE;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            pulse_q <= (st_q == AL_IDLE) && (st_d == AL_FIRED);
        end
    end

    always_comb begin
        status = (st_q == AL_FIRED);
        irq    = irq_en && (level_mode ? status : pulse_q);
    end

    a_r6_fire_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(hit));

    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_go) |=> status);

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> !status);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
    import atmr_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_stb,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic              run_en, count_up, level_mode, alarm_en, slow_sel, irq_en;
    logic              ld_go, snap_go, clr_go, status;
    logic [DIV_W-1:0]  divider;
    logic [DATA_W-1:0] step;
    logic [CNT_W-1:0]  alarm_val, load_val, count, snap;

    atmr_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .run_en(run_en), .count_up(count_up), .level_mode(level_mode),
        .alarm_en(alarm_en), .slow_sel(slow_sel), .divider(divider),
        .step(step), .alarm_val(alarm_val), .load_val(load_val),
        .irq_en(irq_en), .ld_go(ld_go), .snap_go(snap_go), .clr_go(clr_go),
        .snap(snap), .status(status)
    );

    atmr_counter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W),
                   .STEP_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .count_up(count_up),
        .slow_sel(slow_sel), .divider(divider), .step(step),
        .slow_stb(slow_stb), .ld_go(ld_go), .ld_val(load_val),
        .snap_go(snap_go), .count(count), .snap(snap)
    );

    atmr_alarm #(.CNT_W(CNT_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .count(count), .alarm_val(alarm_val),
        .alarm_en(alarm_en), .level_mode(level_mode), .irq_en(irq_en),
        .clr_go(clr_go), .status(status), .irq(irq)
    );
endmodule

// File: tb/tb_alarm_timer64.sv
`timescale 1ns/1ps
module tb_alarm_timer64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_stb = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_STEP = 8'h04, A_ALO = 8'h08,
        A_AHI = 8'h0C, A_LLO = 8'h10, A_LHI = 8'h14, A_LGO = 8'h18,
        A_SGO = 8'h1C, A_SLO = 8'h20, A_SHI = 8'h24, A_IEN = 8'h28,
        A_IST = 8'h2C, A_ICLR = 8'h30;
    localparam logic [31:0] C_RUN = 32'h1, C_UP = 32'h2, C_LEVEL = 32'h4,
        C_ALEN = 32'h8, C_SLOW = 32'h10;

    alarm_timer64 dut (
        .clk(clk), .rst_n(rst_n), .slow_stb(slow_stb), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic snap64(output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(A_SGO, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_SLO, lo);
        rd(A_SHI, hi);
        v = {hi, lo};
    endtask

    task automatic load64(input logic [63:0] v);
        wr(A_LLO, v[31:0]);
        wr(A_LHI, v[63:32]);
        wr(A_LGO, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_ALO, d);  check("R1 alarm lo", d, 32'hFFFF_FFFF);
        rd(A_AHI, d);  check("R1 alarm hi", d, 32'hFFFF_FFFF);
        rd(A_LLO, d);  check("R1 load lo", d, 0);
        rd(A_LHI, d);  check("R1 load hi", d, 0);
        rd(A_SLO, d);  check("R1 snap lo", d, 0);
        rd(A_IST, d);  check("R1 status", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_load_snap();
        logic [63:0] v;
        load64(64'h1234_5678_9ABC_DEF0);
        snap64(v); check("R4 load value via R3 snapshot", v, 64'h1234_5678_9ABC_DEF0);
        load64(64'h0000_0000_0000_0042);
        repeat (4) @(negedge clk);
        begin
            logic [31:0] lo;
            rd(A_SLO, lo); check("R3 snapshot held until next request", lo, 32'h9ABC_DEF0);
        end
        snap64(v); check("R3 new snapshot", v, 64'h42);
    endtask

    task automatic t_count();
        logic [63:0] v;
        load64(64'h0);
        wr(A_CTRL, C_RUN | C_UP);
        repeat (8) @(negedge clk);
        wr(A_CTRL, 32'h0);
        snap64(v); check("R2 divider 0 ticks every cycle", v, 64'd10);
        load64(64'h0);
        wr(A_CTRL, C_RUN | C_UP | (32'd4 << 16));
        repeat (38) @(negedge clk);
        wr(A_CTRL, 32'h0);
        snap64(v); check("R2 divider 4", v, 64'd10);
        load64(64'h0);
        wr(A_CTRL, C_RUN);
        repeat (10) @(negedge clk);
        wr(A_CTRL, C_UP);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 32'h0);
        snap64(v); check("R2 run or up alone holds", v, 64'd0);
        load64(64'h0000_0000_FFFF_FFFE);
        wr(A_CTRL, C_RUN | C_UP);
        repeat (8) @(negedge clk);
        wr(A_CTRL, 32'h0);
        snap64(v); check("R4 carry into high half", v, 64'h1_0000_0008);
    endtask

    task automatic t_snap_running();
        logic [63:0] a, b;
        load64(64'h0);
        wr(A_CTRL, C_RUN | C_UP);
        snap64(a);
        wr(A_CTRL, 32'h0);
        snap64(b);
        check("R3 running snapshot within bounds", (a > 0 && a <= b) ? 64'd1 : 64'd0, 64'd1);
    endtask

    task automatic t_slow();
        logic [63:0] v;
        load64(64'h0);
        wr(A_STEP, 32'd786432);   // 1.5 with 19 fractional bits
        wr(A_CTRL, C_RUN | C_UP | C_SLOW);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); slow_stb = 1'b1;
            @(negedge clk); slow_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
        wr(A_CTRL, 32'h0);
        snap64(v); check("R5 three slow steps of 1.5", v, 64'd4);
    endtask

    task automatic t_alarm_level();
        logic [31:0] d;
        load64(64'd100);
        wr(A_ALO, 32'd105);
        wr(A_AHI, 32'd0);
        wr(A_IEN, 32'h1);
        wr(A_CTRL, C_RUN | C_UP | C_LEVEL | C_ALEN);
        rd(A_IST, d); check("R6 not before reaching alarm", d, 0);
        repeat (12) @(negedge clk);
        rd(A_IST, d); check("R6 status after reach", d, 1);
        check("R9 level irq", irq, 1);
        wr(A_CTRL, C_LEVEL);
        repeat (3) @(negedge clk);
        rd(A_IST, d); check("R7 status kept after alarm disable", d, 1);
        wr(A_ICLR, 32'h1);
        rd(A_IST, d); check("R8 clear", d, 0);
        check("R9 irq low after clear", irq, 0);
        repeat (5) @(negedge clk);
        rd(A_IST, d); check("R7 disabled alarm does not set", d, 0);
    endtask

    task automatic t_alarm_past();
        logic [31:0] d;
        int hi_cnt;
        wr(A_CTRL, 32'h0);
        load64(64'd500);
        wr(A_ALO, 32'd400);
        wr(A_CTRL, C_ALEN | C_LEVEL);
        rd(A_IST, d); check("R6 alarm below count fires at once", d, 1);
        wr(A_IEN, 32'h0);
        check("R9 irq gated by enable", irq, 0);
        wr(A_IEN, 32'h1);
        check("R9 irq follows enable", irq, 1);
        wr(A_CTRL, C_LEVEL);
        wr(A_ICLR, 32'h1);
        wr(A_CTRL, C_ALEN);  // edge mode
        hi_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (irq) hi_cnt++;
        end
        check("R10 edge pulse count", hi_cnt, 1);
        rd(A_IST, d); check("R10 status stays set", d, 1);
        wr(A_CTRL, 32'h0);
        wr(A_ICLR, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h34, d);  check("R11 unmapped 0x34", d, 0);
        rd(8'hFC, d);  check("R11 unmapped 0xFC", d, 0);
        rd(A_LGO, d);  check("R11 load trigger reads 0", d, 0);
        rd(A_SGO, d);  check("R11 snapshot trigger reads 0", d, 0);
        rd(A_ICLR, d); check("R11 clear reads 0", d, 0);
        rd(8'h21, d);  check("R11 misaligned reads 0", d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_snap();
        t_count();
        t_snap_running();
        t_slow();
        t_alarm_level();
        t_alarm_past();
        t_unmapped();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule